// File: doc/BRIEF.md
# SPI Configuration Register Slave

This block is the configuration port of a serial-video cable receiver. An external host reaches five 8-bit registers through a four-wire SPI link: serial clock, data in, active-low select and data out. The data-out pin can be tri-stated. Three of the registers hold settings that the block drives as plain control outputs to the equalizer datapath: mute, bypass, sleep policy, extended reach, output swing and offset, and launch-amplitude trim. The other two are read-only. One reports the cable-length code that arrives on a status input. The other returns a fixed revision byte. The carrier-present input also appears in the top bit of the general register.

The SPI pins are asynchronous to the system clock. Each one passes through a synchroniser, and the serial clock edges are detected in the system domain, so the system clock must run at least four times the serial clock rate. The block has no streaming interface and no back-pressure. All control and status pins are level signals, and the outputs change only after a write frame completes.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset the control outputs hold their default values: mute 0, bypass 0, sleep_mode 01, ext_reach 0, out_swing 011, out_offset 001, launch_coarse 0, launch_fine 0000. MISO is not driven.
- R2: A write frame has 16 bits and is sent MSB first while select is low. The bits are a 0 command bit, a 7-bit address and an 8-bit data byte, each taken on a rising SCK edge. After the 16th bit, the addressed register takes the byte. Register 0 holds mute in bit 6, bypass in bit 5, sleep_mode in bits 4:3 and ext_reach in bit 2. Register 1 holds swing in bits 7:5 and offset in bits 4:2. Register 2 holds coarse in bit 7 and fine in bits 6:3.
- R3: A read frame starts with a 1 command bit followed by a 7-bit address. The register is captured after the 8th rising SCK edge. Its 8 bits leave on MISO MSB first, with the first bit driven from the falling edge of the 8th clock and one new bit on each later falling edge. MISO is enabled while these bits are shifted out.
- R4: Bit 7 of register 0 returns the carrier-present input as it stands at capture time (1 = carrier present). It is not writable.
- R5: Register 3 returns the 5-bit length code in bits 7:3 with zeros in bits 2:0. Register 4 returns 8'h02.
- R6: Reserved bits ignore writes and read as zero. These are bits 1:0 of registers 0 and 1, and bits 2:0 of register 2.
- R7: Writes to registers 3 and 4, and to addresses 05h through 7Fh, change nothing. Reads from addresses 05h through 7Fh return 00h.
- R8: If select rises before the 16th bit of a write, no register changes. The bit count restarts, so the next complete frame is decoded correctly.
- R9: MISO is not driven while select is high or at any time during a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | SPI data from host |
| spi_ss_n | input | 1 | SPI select, active low |
| spi_miso | output | 1 | SPI data to host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| carrier_in | input | 1 | Carrier-present status, 1 = present |
| cable_len | input | 5 | Cable-length code, 0 to 25 |
| mute | output | 1 | Output mute control |
| bypass | output | 1 | Equalizer bypass control |
| sleep_mode | output | 2 | Sleep policy code |
| ext_reach | output | 1 | Extended-reach enable |
| out_swing | output | 3 | Output swing code |
| out_offset | output | 3 | Output offset code |
| launch_coarse | output | 1 | Coarse launch-amplitude select |
| launch_fine | output | 4 | Fine launch-amplitude trim |

## Verification
The assertions assume that every SCK level lasts at least two system clocks, so that no edge is lost in the synchroniser. They also assume MOSI is stable around each rising edge and select stays high for several system clocks between frames. The stimulus holds each SCK phase for four system clocks, changes MOSI only while SCK is low, and keeps select high for at least twelve clocks between frames. The status inputs change only while select is high, so a read captures a settled carrier bit and length code.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

  localparam int REG_W   = 8;
  localparam int RW_REGS = 3;
  localparam logic [REG_W-1:0] DIE_REVISION = 8'h02;

  typedef struct packed {
    logic       mute;
    logic       bypass;
    logic [1:0] sleep_mode;
    logic       ext_reach;
    logic [2:0] out_swing;
    logic [2:0] out_offset;
    logic       launch_coarse;
    logic [3:0] launch_fine;
  } cfg_fields_t;

  // Writable bit mask of each read/write register.
  function automatic logic [REG_W-1:0] rw_mask(input int idx);
    case (idx)
      0:       rw_mask = 8'h7C;
      1:       rw_mask = 8'hFC;
      default: rw_mask = 8'hF8;
    endcase
  endfunction

  // Reset value of each read/write register.
  function automatic logic [REG_W-1:0] rw_default(input int idx);
    case (idx)
      0:       rw_default = 8'h08;
      1:       rw_default = 8'h64;
      default: rw_default = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_raw,
  input  logic mosi_raw,
  input  logic ss_n_raw,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic ss_n_s
);

  localparam int LANES = 3;  // {ss_n, mosi, sck}
  localparam logic [LANES-1:0] IDLE = 3'b100;

  logic [LANES-1:0] stage [SYNC_STAGES];
  logic             sck_prev;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= IDLE;
        else        stage[0] <= {ss_n_raw, mosi_raw, sck_raw};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= IDLE;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= stage[SYNC_STAGES-1][0];
  end

  assign sck_rise = stage[SYNC_STAGES-1][0] & ~sck_prev;
  assign sck_fall = ~stage[SYNC_STAGES-1][0] & sck_prev;
  assign mosi_s   = stage[SYNC_STAGES-1][1];
  assign ss_n_s   = stage[SYNC_STAGES-1][2];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              ss_n_s,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso_q,
  output logic              miso_en
);

  localparam int CMD_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = CMD_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int SHR_W      = FRAME_BITS - 1;

  logic [CNT_W-1:0]  bit_cnt;
  logic [SHR_W-1:0]  shreg;
  logic              is_read;
  logic [DATA_W-1:0] tx_buf;

  logic take_bit, at_cmd_end, at_frame_end, cmd_is_read;

  assign take_bit     = sck_rise & ~ss_n_s & (bit_cnt < CNT_W'(FRAME_BITS));
  assign at_cmd_end   = bit_cnt == CNT_W'(CMD_BITS - 1);
  assign at_frame_end = bit_cnt == CNT_W'(FRAME_BITS - 1);
  // At the 8th rise the command bit sits just above the 6 address bits held so far.
  assign cmd_is_read  = shreg[CMD_BITS-2];
  assign rd_addr      = {shreg[ADDR_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      is_read <= 1'b0;
      tx_buf  <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      miso_q  <= 1'b0;
      miso_en <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (ss_n_s) begin
        bit_cnt <= '0;
        is_read <= 1'b0;
        miso_en <= 1'b0;
        miso_q  <= 1'b0;
      end else begin
        if (take_bit) begin
          shreg   <= {shreg[SHR_W-2:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (at_cmd_end && cmd_is_read) begin
            is_read <= 1'b1;
            tx_buf  <= rd_data;
          end
          if (at_frame_end && !is_read) begin
            wr_stb  <= 1'b1;
            wr_addr <= shreg[DATA_W-1 +: ADDR_W];
            wr_data <= {shreg[DATA_W-2:0], mosi_s};
          end
        end
        if (sck_fall && is_read) begin
          miso_q  <= tx_buf[DATA_W-1];
          tx_buf  <= {tx_buf[DATA_W-2:0], 1'b0};
          miso_en <= 1'b1;
        end
      end
    end
  end

  assert_frame_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS));

  assert_no_write_after_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ss_n_s) |-> !wr_stb);

  assert_miso_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_s |=> !miso_en);

  assert_miso_only_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miso_en |-> is_read);

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_spi_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              carrier_in,
  input  logic [LEN_W-1:0]  cable_len,
  output cfg_fields_t       cfg_o
);

  localparam int ADDR_LENGTH = RW_REGS;
  localparam int ADDR_IDENT  = RW_REGS + 1;

  logic [REG_W-1:0] ctl [RW_REGS];

  for (genvar g = 0; g < RW_REGS; g++) begin : g_rw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctl[g] <= rw_default(g);
      else if (wr_en && wr_addr == ADDR_W'(g))
        ctl[g] <= wr_data & rw_mask(g);
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < RW_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = ctl[i];
    if (rd_addr == '0)
      rd_data[REG_W-1] = carrier_in;
    if (rd_addr == ADDR_W'(ADDR_LENGTH))
      rd_data = {cable_len, {(REG_W-LEN_W){1'b0}}};
    if (rd_addr == ADDR_W'(ADDR_IDENT))
      rd_data = DIE_REVISION;
  end

  always_comb begin
    cfg_o.mute          = ctl[0][6];
    cfg_o.bypass        = ctl[0][5];
    cfg_o.sleep_mode    = ctl[0][4:3];
    cfg_o.ext_reach     = ctl[0][2];
    cfg_o.out_swing     = ctl[1][7:5];
    cfg_o.out_offset    = ctl[1][4:2];
    cfg_o.launch_coarse = ctl[2][7];
    cfg_o.launch_fine   = ctl[2][6:3];
  end

  assert_ro_and_unmapped_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADDR_W'(RW_REGS)) |=> $stable(cfg_o));

  assert_unmapped_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr > ADDR_W'(ADDR_IDENT)) |-> (rd_data == '0));

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import cfg_spi_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int LEN_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  input  logic             spi_ss_n,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  input  logic             carrier_in,
  input  logic [LEN_W-1:0] cable_len,
  output logic             mute,
  output logic             bypass,
  output logic [1:0]       sleep_mode,
  output logic             ext_reach,
  output logic [2:0]       out_swing,
  output logic [2:0]       out_offset,
  output logic             launch_coarse,
  output logic [3:0]       launch_fine
);

  logic              sck_rise, sck_fall, mosi_s, ss_n_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [REG_W-1:0]  rd_data, wr_data;
  logic              wr_stb, miso_q, miso_en;
  cfg_fields_t       cfg;

  spi_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_raw  (spi_sck),
    .mosi_raw (spi_mosi),
    .ss_n_raw (spi_ss_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s),
    .ss_n_s   (ss_n_s)
  );

  spi_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s),
    .ss_n_s   (ss_n_s),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .miso_q   (miso_q),
    .miso_en  (miso_en)
  );

  cfg_reg_bank #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .carrier_in (carrier_in),
    .cable_len  (cable_len),
    .cfg_o      (cfg)
  );

  assign spi_miso      = miso_en & miso_q;
  assign spi_miso_oe   = miso_en;
  assign mute          = cfg.mute;
  assign bypass        = cfg.bypass;
  assign sleep_mode    = cfg.sleep_mode;
  assign ext_reach     = cfg.ext_reach;
  assign out_swing     = cfg.out_swing;
  assign out_offset    = cfg.out_offset;
  assign launch_coarse = cfg.launch_coarse;
  assign launch_fine   = cfg.launch_fine;

endmodule

// File: tb/spi_cfg_slave_test.sv
`timescale 1ns/1ps
module spi_cfg_slave_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic carrier = 1'b0;
  logic [4:0] len = 5'd0;
  logic miso, miso_oe, mute, bypass, ext_reach, coarse;
  logic [1:0] sleep_mode;
  logic [2:0] swing, offset;
  logic [3:0] fine;

  always #2.5 clk = ~clk;

  spi_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_ss_n(ss_n),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .carrier_in(carrier), .cable_len(len),
    .mute(mute), .bypass(bypass), .sleep_mode(sleep_mode), .ext_reach(ext_reach),
    .out_swing(swing), .out_offset(offset), .launch_coarse(coarse), .launch_fine(fine)
  );

  int total = 0;
  int bad = 0;
  int ss_hi = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Behavioural register model.
  logic [7:0] m0 = 8'h08, m1 = 8'h64, m2 = 8'h00;

  function automatic logic [7:0] model_read(input int a);
    case (a)
      0: return {carrier, m0[6:0]};
      1: return m1;
      2: return m2;
      3: return {len, 3'b000};
      4: return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input int a, input logic [7:0] d);
    case (a)
      0: m0 = d & 8'h7C;
      1: m1 = d & 8'hFC;
      2: m2 = d & 8'hF8;
      default: ;
    endcase
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model while the link is idle.
  always @(negedge clk) begin
    if (rst_n && ss_hi >= 8 && !done) begin
      chk(mute == m0[6],            "R2 mute",    mute, m0[6]);
      chk(bypass == m0[5],          "R2 bypass",  bypass, m0[5]);
      chk(sleep_mode == m0[4:3],    "R2 sleep",   sleep_mode, m0[4:3]);
      chk(ext_reach == m0[2],       "R2 ext",     ext_reach, m0[2]);
      chk(swing == m1[7:5],         "R2 swing",   swing, m1[7:5]);
      chk(offset == m1[4:2],        "R2 offset",  offset, m1[4:2]);
      chk(coarse == m2[7],          "R2 coarse",  coarse, m2[7]);
      chk(fine == m2[6:3],          "R2 fine",    fine, m2[6:3]);
      chk(miso_oe == 1'b0,          "R9 idle oe", miso_oe, 0);
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
    if (ss_n) ss_hi++; else ss_hi = 0;
  endtask

  task automatic spi_bit(input logic b);
    mosi = b; sck = 1'b0;
    repeat (4) tick();
    sck = 1'b1;
    repeat (4) tick();
  endtask

  task automatic finish_frame;
    sck = 1'b0;
    repeat (4) tick();
    ss_n = 1'b1;
    repeat (12) tick();
  endtask

  task automatic spi_write(input int a, input logic [7:0] d);
    logic [15:0] f;
    f = {1'b0, 7'(a), d};
    ss_n = 1'b0;
    repeat (4) tick();
    for (int i = 15; i >= 0; i--) begin
      spi_bit(f[i]);
      chk(miso_oe == 1'b0, "R9 write oe", miso_oe, 0);
    end
    model_write(a, d);
    finish_frame();
  endtask

  task automatic spi_read(input int a, input string tag);
    logic [7:0] got, exp;
    logic [7:0] f;
    exp = model_read(a);
    f = {1'b1, 7'(a)};
    got = '0;
    ss_n = 1'b0;
    repeat (4) tick();
    for (int i = 7; i >= 0; i--) spi_bit(f[i]);
    mosi = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      repeat (4) tick();
      chk(miso_oe == 1'b1, "R3 read oe", miso_oe, 1);
      got[i] = miso;
      sck = 1'b1;
      repeat (4) tick();
    end
    chk(got == exp, tag, got, exp);
    finish_frame();
  endtask

  task automatic spi_abort(input int a, input logic [7:0] d, input int nbits);
    logic [15:0] f;
    f = {1'b0, 7'(a), d};
    ss_n = 1'b0;
    repeat (4) tick();
    for (int i = 15; i > 15 - nbits; i--) spi_bit(f[i]);
    finish_frame();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (10) tick();
    // R1 reset state
    chk({mute, bypass, sleep_mode, ext_reach} == 5'b00010, "R1 ctl0 defaults",
        {mute, bypass, sleep_mode, ext_reach}, 5'b00010);
    chk({swing, offset} == 6'b011001, "R1 driver defaults", {swing, offset}, 6'b011001);
    chk({coarse, fine} == 5'b0, "R1 launch defaults", {coarse, fine}, 0);
    chk(miso_oe == 1'b0, "R1 miso off", miso_oe, 0);
    spi_read(0, "R1 read reg0 default");
    spi_read(1, "R1 read reg1 default");
    spi_read(2, "R1 read reg2 default");
    // R4 / R5 status registers
    carrier = 1'b1; len = 5'd25; repeat (4) tick();
    spi_read(0, "R4 carrier bit set");
    spi_read(3, "R5 length 25");
    len = 5'd0; repeat (4) tick();
    spi_read(3, "R5 length 0");
    len = 5'd18; carrier = 1'b0; repeat (4) tick();
    spi_read(3, "R5 length 18");
    spi_read(0, "R4 carrier bit clear");
    spi_read(4, "R5 revision");
    carrier = 1'b1; repeat (4) tick();
    // R2 writes
    spi_write(0, 8'h74);
    spi_read(0, "R2 reg0 readback");
    spi_write(1, 8'h80);
    spi_read(1, "R2 reg1 readback");
    spi_write(2, 8'hB8);
    spi_read(2, "R2 reg2 readback");
    spi_write(1, 8'h1C);
    spi_read(1, "R2 reg1 second value");
    // R6 reserved bits
    spi_write(0, 8'hFF);
    spi_read(0, "R6 reg0 reserved zero");
    spi_write(1, 8'hFF);
    spi_read(1, "R6 reg1 reserved zero");
    spi_write(2, 8'hFF);
    spi_read(2, "R6 reg2 reserved zero");
    // R7 read-only and unmapped
    spi_write(3, 8'hFF);
    spi_write(4, 8'h55);
    spi_write(5, 8'h00);
    spi_write(127, 8'h00);
    spi_read(3, "R7 reg3 unchanged");
    spi_read(4, "R7 reg4 unchanged");
    spi_read(5, "R7 unmapped 05");
    spi_read(64, "R7 unmapped 40");
    spi_read(127, "R7 unmapped 7F");
    spi_read(2, "R7 reg2 kept");
    // R8 aborted frames
    spi_write(0, 8'h08);
    spi_abort(0, 8'h7C, 15);
    spi_read(0, "R8 abort 15 bits");
    spi_abort(1, 8'h00, 10);
    spi_abort(2, 8'h00, 3);
    spi_read(1, "R8 abort 10 bits");
    spi_write(2, 8'h48);
    spi_read(2, "R8 frame after abort");
    spi_write(0, 8'h50);
    spi_read(0, "R3 final reg0");
    repeat (20) tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule